// File: doc/BRIEF.md
# Graphics Interrupt Control Register Block

This block is the host-facing control and status register set of a graphics engine. It holds a command/status register whose event bits are cleared by writing ones, a write-only interrupt mask register, and a signal ID register. It drives a single interrupt request line toward the host. The drawing engine reports horizontal sync, vertical sync, edge-write completion, finish, and queued signal events with their data and mask words. The block returns a one-cycle resume strobe to the transfer engine when a paused signal is acknowledged.

The host reaches the block through a simple synchronous register bus that carries 8, 16, 32 and 64-bit accesses. A write to the command/status register is a set of actions, not a stored value. A narrow write acts only on its own byte lanes, and every other bit counts as zero, which means no action. Reads of any address outside the signal ID window return the command/status register, so the mask register cannot be read back.

Top module: `gfx_irq_regs`

## Requirements
- R1: After reset, status bits 4:0 are zero, the signal ID is zero, no signal is queued, and all five mask bits (mask register bits 12:8) are set. The command/status read value is {32'h0, ID_REV, 11'h0, status[4:0]}, with bit 0 signal, bit 1 finish, bit 2 hsync, bit 3 vsync and bit 4 edge-write.
- R2: A write of size 1, 2, 4 or 8 bytes (bus_size 0..3) at byte lane L = addr[2:0] acts as the command value (wdata masked to its size) << 8·L. Bits outside that value are zero and have no effect. Bits 31:16 are read-only constants.
- R3: In a command write with bit 9 (reset) clear, a one in bit 1, 2, 3 or 4 clears the matching status bit. A zero leaves the bit unchanged.
- R4: A one-cycle pulse on fin/hs/vs/edw sets status bit 1/2/3/4 in the next cycle. A pulse wins over a clear written in the same cycle.
- R5: A write to the mask register address (window offset 0) keeps only bits 12:8 of the aligned value, and bits 14:13 are forced to one. Mask bit 8+k masks status bit k.
- R6: A mask write raises the interrupt at once when status & ((~new & old) >> 8) is non-zero.
- R7: A write of one to command bit 0 with a signal queued sets ID = (ID & ~mask) | (data & mask) and sets status bit 0. It raises the interrupt unless mask bit 8 is set. With no signal queued, status bit 0 is cleared. The queue is emptied in both cases.
- R8: A write of one to command bit 0 while status bit 0 was already set produces a one-cycle resume_o pulse.
- R9: Reads inside the signal ID 16-byte window return the ID; any other address returns the command/status register. The read data is the 16-byte window (upper 8 bytes zero) shifted right by 8·addr[3:0], masked to the access size, and presented one cycle after bus_rd_i.
- R10: A command write with bit 9 set clears status, ID and the signal queue, restores the mask to 16'h7F00, and ignores the other bits of that write.
- R11: irq_o is a one-cycle pulse that follows R6, R7, or any event pulse whose mask bit is clear after that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| bus_wdata_i | input | 64 | Write data, right-aligned |
| bus_rdata_o | output | 64 | Read data, one cycle after the read strobe |
| sig_evt_i | input | 1 | Signal event pulse, queues data and mask |
| sig_data_i | input | ID_W | Signal ID data word |
| sig_mask_i | input | ID_W | Signal ID mask word |
| fin_evt_i | input | 1 | Finish event pulse |
| hs_evt_i | input | 1 | Horizontal sync pulse |
| vs_evt_i | input | 1 | Vertical sync pulse |
| edw_evt_i | input | 1 | Edge-write done pulse |
| irq_o | output | 1 | Interrupt request pulse |
| resume_o | output | 1 | Resume strobe to the transfer engine |

## Verification
The embedded assertions check four properties on every cycle:
- the forced and kept bits of the mask register;
- that a set beats a same-cycle hsync clear;
- that a status clear takes effect;
- that an unmask of a pending event always yields an interrupt.

They also check that a resume pulse only follows a set signal status.

The bench's scenarios are needed for the rest:
- the byte-lane alignment of every write size;
- the mirrored read data at arbitrary offsets;
- the masked ID merge;
- the reset command, which discards the other bits of its write.

These are compared against a reference model in the bench across sweeps of lanes, patterns and addresses.

// File: rtl/girq_pkg.sv
package girq_pkg;

    localparam int NUM_EVT   = 5;
    localparam int CMD_W     = 16;
    localparam int MASK_LSB  = 8;

    localparam int BIT_SIG   = 0;
    localparam int BIT_FIN   = 1;
    localparam int BIT_HS    = 2;
    localparam int BIT_VS    = 3;
    localparam int BIT_EDW   = 4;
    localparam int BIT_FLUSH = 8;
    localparam int BIT_RST   = 9;

    localparam logic [CMD_W-1:0] MASK_KEEP  = 16'h1F00;
    localparam logic [CMD_W-1:0] MASK_FORCE = 16'h6000;
    localparam logic [CMD_W-1:0] MASK_RESET = 16'h7F00;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    function automatic logic [63:0] size_mask(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: size_mask = 64'h0000_0000_0000_00FF;
            SZ_HALF: size_mask = 64'h0000_0000_0000_FFFF;
            SZ_WORD: size_mask = 64'h0000_0000_FFFF_FFFF;
            default: size_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/girq_lane_align.sv
module girq_lane_align
    import girq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OUT_W  = CMD_W,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [OUT_W-1:0]  cmd_o
);

    logic [63:0]       full_mask;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] shifted [LANES];

    assign full_mask = size_mask(size_i);
    assign masked    = data_i & full_mask[DATA_W-1:0];

    // one shifter per byte lane, picked by the lane index
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        assign shifted[gl] = masked << (8 * gl);
    end

    logic [DATA_W-1:0] sel;
    assign sel   = shifted[lane_i];
    assign cmd_o = sel[OUT_W-1:0];

    logic unused_hi;
    assign unused_hi = ^sel[DATA_W-1:OUT_W];

endmodule

// File: rtl/girq_rd_mirror.sv
module girq_rd_mirror
    import girq_pkg::*;
#(
    parameter int              ADDR_W     = 13,
    parameter int              DATA_W     = 64,
    parameter logic [ADDR_W-1:0] SIGID_BASE = 13'h1080
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] csr_i,
    input  logic [DATA_W-1:0] id_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int WIN_W = 2 * DATA_W;

    logic              in_id_win;
    logic [DATA_W-1:0] sel;
    logic [WIN_W-1:0]  window;
    logic [WIN_W-1:0]  shifted;
    logic [63:0]       full_mask;

    assign in_id_win = (addr_i[ADDR_W-1:4] == SIGID_BASE[ADDR_W-1:4]);
    assign sel       = in_id_win ? id_i : csr_i;
    assign window    = {{DATA_W{1'b0}}, sel};
    assign shifted   = window >> {addr_i[3:0], 3'b000};
    assign full_mask = size_mask(size_i);
    assign rdata_o   = shifted[DATA_W-1:0] & full_mask[DATA_W-1:0];

    logic unused_hi;
    assign unused_hi = ^shifted[WIN_W-1:DATA_W];

endmodule

// File: rtl/gfx_irq_regs.sv
module gfx_irq_regs
    import girq_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                ID_W       = 32,
    parameter logic [15:0]       ID_REV     = 16'h551B,
    parameter logic [ADDR_W-1:0] CSR_BASE   = 13'h1000,
    parameter logic [ADDR_W-1:0] IMR_BASE   = 13'h1010,
    parameter logic [ADDR_W-1:0] SIGID_BASE = 13'h1080
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [63:0]       bus_wdata_i,
    output logic [63:0]       bus_rdata_o,
    input  logic              sig_evt_i,
    input  logic [ID_W-1:0]   sig_data_i,
    input  logic [ID_W-1:0]   sig_mask_i,
    input  logic              fin_evt_i,
    input  logic              hs_evt_i,
    input  logic              vs_evt_i,
    input  logic              edw_evt_i,
    output logic              irq_o,
    output logic              resume_o
);

    localparam int DATA_W = 64;
    localparam int WIN_HI = ADDR_W - 1;

    typedef struct packed {
        logic [NUM_EVT-1:0] stat;
        logic [CMD_W-1:0]   imr;
        logic [ID_W-1:0]    id;
        logic               sq;
        logic [ID_W-1:0]    sdata;
        logic [ID_W-1:0]    smask;
        logic               irq;
        logic               resume;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    localparam state_t RESET_STATE = '{
        stat:   '0,
        imr:    MASK_RESET,
        id:     '0,
        sq:     1'b0,
        sdata:  '0,
        smask:  '0,
        irq:    1'b0,
        resume: 1'b0,
        rdata:  '0
    };

    state_t q, d;

    logic [CMD_W-1:0]   cmd;
    logic [DATA_W-1:0]  csr_val;
    logic [DATA_W-1:0]  id_val;
    logic [DATA_W-1:0]  rd_val;
    logic               csr_hit;
    logic               imr_hit;
    logic [CMD_W-1:0]   new_imr;
    logic [CMD_W-1:0]   unmask_vec;
    logic [NUM_EVT-1:0] unmask_hit;
    logic [NUM_EVT-1:0] evt_set;

    girq_lane_align #(
        .DATA_W (DATA_W),
        .OUT_W  (CMD_W)
    ) u_align (
        .lane_i (bus_addr_i[2:0]),
        .size_i (bus_size_i),
        .data_i (bus_wdata_i),
        .cmd_o  (cmd)
    );

    assign csr_val = {32'h0, ID_REV, 11'h0, q.stat};
    assign id_val  = {{(DATA_W-ID_W){1'b0}}, q.id};

    girq_rd_mirror #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SIGID_BASE (SIGID_BASE)
    ) u_mirror (
        .addr_i  (bus_addr_i),
        .size_i  (bus_size_i),
        .csr_i   (csr_val),
        .id_i    (id_val),
        .rdata_o (rd_val)
    );

    assign csr_hit = bus_wr_i && (bus_addr_i[WIN_HI:4] == CSR_BASE[WIN_HI:4]) && !bus_addr_i[3];
    assign imr_hit = bus_wr_i && (bus_addr_i[WIN_HI:4] == IMR_BASE[WIN_HI:4]) && !bus_addr_i[3];

    assign new_imr    = (cmd & MASK_KEEP) | MASK_FORCE;
    assign unmask_vec = (~new_imr & q.imr) >> MASK_LSB;
    assign unmask_hit = q.stat & unmask_vec[NUM_EVT-1:0];
    assign evt_set    = {edw_evt_i, vs_evt_i, hs_evt_i, fin_evt_i, 1'b0};

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        d.resume = 1'b0;

        if (csr_hit) begin
            if (cmd[BIT_RST]) begin
                d.stat = '0;
                d.imr  = MASK_RESET;
                d.id   = '0;
                d.sq   = 1'b0;
            end else begin
                if (cmd[BIT_SIG]) begin
                    d.resume = q.stat[BIT_SIG];
                    if (q.sq) begin
                        d.id            = (q.id & ~q.smask) | (q.sdata & q.smask);
                        d.stat[BIT_SIG] = 1'b1;
                        if (!q.imr[MASK_LSB + BIT_SIG]) begin
                            d.irq = 1'b1;
                        end
                    end else begin
                        d.stat[BIT_SIG] = 1'b0;
                    end
                    d.sq = 1'b0;
                end
                for (int k = BIT_FIN; k < NUM_EVT; k++) begin
                    if (cmd[k]) begin
                        d.stat[k] = 1'b0;
                    end
                end
            end
        end

        if (imr_hit) begin
            if (|unmask_hit) begin
                d.irq = 1'b1;
            end
            d.imr = new_imr;
        end

        d.stat = d.stat | evt_set;
        if (|(evt_set & ~d.imr[MASK_LSB +: NUM_EVT])) begin
            d.irq = 1'b1;
        end

        if (sig_evt_i) begin
            d.sq    = 1'b1;
            d.sdata = sig_data_i;
            d.smask = sig_mask_i;
        end

        if (bus_rd_i) begin
            d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata_o = q.rdata;
    assign irq_o       = q.irq;
    assign resume_o    = q.resume;

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    AST_IMR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.imr[14:13] == 2'b11) && ((q.imr & ~16'h7F00) == 16'h0)); // R5

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(hs_evt_i)) |-> q.stat[BIT_HS]); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_hit && cmd[BIT_VS] && !vs_evt_i) |=> !q.stat[BIT_VS]); // R3

    AST_UNMASK_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imr_hit && (|unmask_hit)) |=> irq_o); // R6

    AST_RESUME_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && resume_o) |-> $past(q.stat[BIT_SIG])); // R8

endmodule

// File: tb/gfx_irq_regs_test.sv
module gfx_irq_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] REV = 16'h551B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [12:0] addr = '0;
    logic [1:0]  sz = '0;
    logic [63:0] wd = '0;
    logic [63:0] rdata;
    logic        sg = 1'b0;
    logic [31:0] sdat = '0, smsk = '0;
    logic        fin = 1'b0, hs = 1'b0, vs = 1'b0, edw = 1'b0;
    logic        irq, resume;

    int checks = 0;
    int failures = 0;

    logic [4:0]  m_stat;
    logic [15:0] m_imr;
    logic [31:0] m_id, m_sd, m_sm;
    logic        m_sq;

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_irq_regs uut (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_size_i(sz),
        .bus_wdata_i(wd), .bus_rdata_o(rdata),
        .sig_evt_i(sg), .sig_data_i(sdat), .sig_mask_i(smsk),
        .fin_evt_i(fin), .hs_evt_i(hs), .vs_evt_i(vs), .edw_evt_i(edw),
        .irq_o(irq), .resume_o(resume)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] szm(input logic [1:0] s);
        return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << (8 << s)) - 64'h1);
    endfunction

    function automatic logic [63:0] model_read(input logic [12:0] a, input logic [1:0] s);
        logic [63:0]  base;
        logic [127:0] win;
        base = (a[12:4] == 9'h108) ? {32'h0, m_id} : {32'h0, REV, 11'h0, m_stat};
        win  = {64'h0, base} >> (8 * a[3:0]);
        return win[63:0] & szm(s);
    endfunction

    task automatic model_reset();
        m_stat = '0; m_imr = 16'h7F00; m_id = '0; m_sd = '0; m_sm = '0; m_sq = 1'b0;
    endtask

    // one bus cycle plus event pulses; checks irq, resume and read data
    task automatic step(input logic w, input logic r, input logic [12:0] a, input logic [1:0] s,
                        input logic [63:0] data, input logic [4:0] ev, input logic sgv,
                        input logic [31:0] sd, input logic [31:0] sm, input string tag);
        logic [63:0] cmd;
        logic [15:0] nimr;
        logic [4:0]  unm;
        logic        e_irq, e_res;
        logic [63:0] e_rd;
        e_irq = 1'b0; e_res = 1'b0;
        e_rd  = model_read(a, s);
        cmd   = (data & szm(s)) << (8 * a[2:0]);
        if (w && a[12:4] == 9'h100 && !a[3]) begin
            if (cmd[9]) begin
                model_reset();
            end else begin
                if (cmd[0]) begin
                    e_res = m_stat[0];
                    if (m_sq) begin
                        m_id = (m_id & ~m_sm) | (m_sd & m_sm);
                        m_stat[0] = 1'b1;
                        if (!m_imr[8]) e_irq = 1'b1;
                    end else begin
                        m_stat[0] = 1'b0;
                    end
                    m_sq = 1'b0;
                end
                m_stat[4:1] = m_stat[4:1] & ~cmd[4:1];
            end
        end
        if (w && a[12:4] == 9'h101 && !a[3]) begin
            nimr = (cmd[15:0] & 16'h1F00) | 16'h6000;
            unm  = m_stat & 5'((~nimr & m_imr) >> 8);
            if (|unm) e_irq = 1'b1;
            m_imr = nimr;
        end
        m_stat = m_stat | ev;
        if (|(ev & ~m_imr[12:8])) e_irq = 1'b1;
        if (sgv) begin m_sq = 1'b1; m_sd = sd; m_sm = sm; end
        wr = w; rd = r; addr = a; sz = s; wd = data;
        {edw, vs, hs, fin} = ev[4:1]; sg = sgv; sdat = sd; smsk = sm;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; {edw, vs, hs, fin} = 4'h0; sg = 1'b0;
        chk(irq === e_irq, {tag, " R11 irq"}, {63'h0, irq}, {63'h0, e_irq});
        chk(resume === e_res, {tag, " R8 resume"}, {63'h0, resume}, {63'h0, e_res});
        if (r) chk(rdata === e_rd, {tag, " R9 rdata"}, rdata, e_rd);
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [1:0] s, input string tag);
        step(1'b0, 1'b1, a, s, 64'h0, 5'h0, 1'b0, 32'h0, 32'h0, tag);
    endtask

    task automatic wr_do(input logic [12:0] a, input logic [1:0] s, input logic [63:0] data, input string tag);
        step(1'b1, 1'b0, a, s, data, 5'h0, 1'b0, 32'h0, 32'h0, tag);
    endtask

    task automatic ev_do(input logic [4:0] ev, input string tag);
        step(1'b0, 1'b0, 13'h0, 2'd0, 64'h0, ev, 1'b0, 32'h0, 32'h0, tag);
    endtask

    task automatic sig_do(input logic [31:0] sd, input logic [31:0] sm, input string tag);
        step(1'b0, 1'b0, 13'h0, 2'd0, 64'h0, 5'h0, 1'b1, sd, sm, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq === 1'b0 && resume === 1'b0, "R1 reset outputs", {62'h0, irq, resume}, 64'h0);
        rd_chk(13'h1000, 2'd3, "R1 reset csr");
        rd_chk(13'h1080, 2'd3, "R1 reset id");
        rd_chk(13'h1010, 2'd3, "R9 imr mirror");

        // R4: events while all masked set status without irq
        ev_do(5'b11110, "R4 events masked");
        rd_chk(13'h1000, 2'd2, "R4 status set");

        // R5/R6: unmask via 16-bit write; low byte ignored
        wr_do(13'h1010, 2'd1, 64'h00FF, "R6 unmask all");
        rd_chk(13'h1000, 2'd0, "R5 status kept");
        wr_do(13'h1010, 2'd1, 64'h1F00, "R5 remask");
        wr_do(13'h1010, 2'd2, 64'h0000_1B00, "R6 partial unmask");

        // R2/R3/R10: byte-lane sweep over every lane and several patterns
        for (int ln = 0; ln < 8; ln++) begin
            for (int p = 0; p < 7; p++) begin
                logic [7:0] pat;
                case (p)
                    0: pat = 8'h01; 1: pat = 8'h02; 2: pat = 8'h04; 3: pat = 8'h08;
                    4: pat = 8'h10; 5: pat = 8'h1C; default: pat = 8'hFF;
                endcase
                ev_do(5'b11110, "R4 refill");
                wr_do(13'h1000 + 13'(ln), 2'd0, {56'h0, pat}, "R2 byte lane write");
                rd_chk(13'h1000, 2'd3, "R3 after byte write");
                wr_do(13'h1010, 2'd2, 64'h0, "R6 unmask sweep");
            end
        end

        // R2: upper half writes are read-only / no action
        ev_do(5'b11110, "R4 refill2");
        wr_do(13'h1002, 2'd1, 64'hFFFF, "R2 upper half");
        rd_chk(13'h1000, 2'd2, "R2 id/rev const");
        wr_do(13'h1000, 2'd1, 64'h0014, "R3 half clear");
        rd_chk(13'h1000, 2'd1, "R3 half result");

        // R4: set wins over same-cycle clear
        step(1'b1, 1'b0, 13'h1000, 2'd2, 64'h1C, 5'b00100, 1'b0, 32'h0, 32'h0, "R4 set wins");
        rd_chk(13'h1000, 2'd0, "R4 set wins read");

        // R7/R8: signal merge and resume
        sig_do(32'hA5A5_0F0F, 32'hFFFF_00F0, "R7 queue");
        wr_do(13'h1000, 2'd0, 64'h01, "R7 fire");
        rd_chk(13'h1080, 2'd2, "R7 id merge");
        rd_chk(13'h1083, 2'd0, "R9 id byte");
        sig_do(32'h1234_5678, 32'h0000_FFFF, "R7 queue2");
        wr_do(13'h1000, 2'd3, 64'h01, "R8 fire with resume");
        rd_chk(13'h1084, 2'd3, "R9 id offset");
        wr_do(13'h1000, 2'd0, 64'h01, "R8 empty queue resume");
        rd_chk(13'h1000, 2'd0, "R7 status cleared");
        wr_do(13'h1000, 2'd0, 64'h01, "R8 no resume");

        // R7: masked signal raises no irq
        wr_do(13'h1010, 2'd1, 64'h0100, "R5 mask sig");
        sig_do(32'hFFFF_FFFF, 32'h0000_00FF, "R7 queue3");
        wr_do(13'h1000, 2'd0, 64'h01, "R7 masked fire");
        rd_chk(13'h1080, 2'd2, "R7 id merge2");

        // R10: reset command discards queue and other bits
        sig_do(32'h0000_0001, 32'hFFFF_FFFF, "R10 queue");
        ev_do(5'b11110, "R10 events");
        wr_do(13'h1000, 2'd2, 64'h0000_021F, "R10 reset cmd");
        rd_chk(13'h1000, 2'd3, "R10 csr after reset");
        rd_chk(13'h1080, 2'd3, "R10 id after reset");
        wr_do(13'h1000, 2'd0, 64'h01, "R10 queue dropped");
        ev_do(5'b00010, "R10 masked after reset");

        // R9: mirrored reads across the address space
        ev_do(5'b10110, "R9 fill");
        for (int a = 0; a < 8192; a += 37) begin
            rd_chk(13'(a), 2'(a % 4), "R9 mirror sweep");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule